// File: doc/BRIEF.md
# Linked-list DMA descriptor walker

This block is a single-channel DMA engine driven by a chain of transfer elements kept in memory, not by one programmed transfer. After the doorbell, it reads elements one after another through a single-word memory request/response port. Each data element names a byte count, a 64-bit source and a 64-bit destination. The engine copies that data word by word through the same port and then moves on to the next element. A link element sends fetching to another address, so the chain can form a ring.

Each element carries a cycle bit, and that bit decides who owns the element. The engine holds a consumer cycle state. It runs only the elements whose cycle bit equals that state, and it stops when the two differ. A link element can invert the consumer cycle state, which lets software reuse a ring without rewriting the elements it has not touched. Software arms the walk with a list pointer, the starting cycle state and a linked-list enable. The engine signals completion through single-cycle pulses and reports progress on a two-bit status output.

Top module: `llwalk_dma`

## Requirements
- R1: After reset `ch_status` is 0, `mem_req` is low, `ch_ccs` is 0 and all three pulse outputs are low.
- R2: A `db_valid` cycle with `cfg_llen` high while `ch_status` is not 1 starts a walk at `cfg_list_ptr`, loads `ch_ccs` from `cfg_ccs` and sets `ch_status` to 1. A doorbell with `cfg_llen` low is ignored, and so is a doorbell while `ch_status` is 1.
- R3: A data element is six 32-bit words at byte offsets 0 (control), 4 (byte count), 8 and 12 (source low and high), 16 and 20 (destination low and high). The next element follows at offset 24.
- R4: In the control word, bit 0 is the cycle bit, bit 1 inverts the cycle state, bit 2 marks a link element, bit 3 asks for `irq_done` and bit 4 asks for `irq_remote`.
- R5: A data element copies byte count / 4 words (the low two bits are ignored). Each word is read at source+4k and then written at destination+4k, with k rising from 0. A count below 4 moves no data.
- R6: When an element's cycle bit differs from `ch_ccs`, the engine makes no further memory access, sets `ch_status` to 3 and leaves `ch_ccs` as it was.
- R7: In a link element, the words at offsets 4 and 8 are the low and high halves of the next element address, and fetching continues there. If bit 1 is set, `ch_ccs` is inverted first.
- R8: When a data element finishes, `irq_done` pulses for one cycle if bit 3 is set and `irq_remote` pulses for one cycle if bit 4 is set. Otherwise neither pulses.
- R9: An error response to any access ends the walk. It causes one `irq_abort` pulse, sets `ch_status` to 2, produces no done pulse for that element and makes no further access.
- R10: Once `mem_req` is raised, it stays high with address, direction and write data unchanged until `mem_ack`. At most one access is outstanding.
- R11: After a stop or an abort, a new doorbell starts a fresh walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert, released synchronously |
| db_valid | input | 1 | Doorbell, one cycle |
| cfg_llen | input | 1 | Linked-list enable, sampled with the doorbell |
| cfg_ccs | input | 1 | Starting consumer cycle state |
| cfg_list_ptr | input | ADDR_W | First element address |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Byte address of the access |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Completes the pending access |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| mem_err | input | 1 | Error response, valid with `mem_ack` |
| irq_done | output | 1 | Local completion pulse |
| irq_remote | output | 1 | Remote completion pulse |
| irq_abort | output | 1 | Abort pulse |
| ch_status | output | 2 | 0 reset, 1 running, 2 halted on abort, 3 stopped |
| ch_ccs | output | 1 | Current consumer cycle state |

## Verification
The bench targets four kinds of fault. A cycle bit mismatch after a link that inverted the state is one: an engine that forgot the inversion would stop one element early or run into stale elements. Byte counts of zero and three are another, and a bad word counter would underflow and copy far past the destination. An error response in the middle of a copy must leave exactly the words already written and never raise a done pulse. A doorbell rung during a walk must not redirect it. Random chains with random memory latency, random link placement and random cycle inversion are compared word for word and access for access against counts the bench derives from the element list.

// File: rtl/dmaw_pkg.sv
package dmaw_pkg;
  localparam int WORD_W          = 32;
  localparam int WORD_BYTES      = WORD_W / 8;
  localparam int WB_SHIFT        = $clog2(WORD_BYTES);
  localparam int DATA_ELEM_WORDS = 6;
  localparam int FLD_W           = $clog2(DATA_ELEM_WORDS);

  // control word bit positions (software builds elements with these)
  localparam int CTL_CB  = 0;
  localparam int CTL_TCB = 1;
  localparam int CTL_LLP = 2;
  localparam int CTL_LIE = 3;
  localparam int CTL_RIE = 4;

  // word index inside an element
  localparam logic [FLD_W-1:0] FLD_CTL    = FLD_W'(0);
  localparam logic [FLD_W-1:0] FLD_SIZE   = FLD_W'(1);
  localparam logic [FLD_W-1:0] FLD_SRC_LO = FLD_W'(2);
  localparam logic [FLD_W-1:0] FLD_SRC_HI = FLD_W'(3);
  localparam logic [FLD_W-1:0] FLD_DST_LO = FLD_W'(4);
  localparam logic [FLD_W-1:0] FLD_DST_HI = FLD_W'(5);
  localparam logic [FLD_W-1:0] FLD_LNK_LO = FLD_W'(1);

  typedef enum logic [1:0] {
    CH_RESET = 2'd0,
    CH_RUN   = 2'd1,
    CH_HALT  = 2'd2,
    CH_STOP  = 2'd3
  } ch_status_e;

  typedef enum logic [1:0] {
    W_IDLE,
    W_FETCH,
    W_COPY_RD,
    W_COPY_WR
  } walk_state_e;

  typedef struct packed {
    logic rie;
    logic lie;
    logic llp;
    logic tcb;
    logic cb;
  } elem_ctl_t;
endpackage

// File: rtl/dmaw_ctl_decode.sv
module dmaw_ctl_decode
  import dmaw_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output elem_ctl_t         ctl
);
  logic unused_hi;

  always_comb begin
    ctl.cb  = word[CTL_CB];
    ctl.tcb = word[CTL_TCB];
    ctl.llp = word[CTL_LLP];
    ctl.lie = word[CTL_LIE];
    ctl.rie = word[CTL_RIE];
  end

  assign unused_hi = ^word[WORD_W-1:CTL_RIE+1];
endmodule

// File: rtl/dmaw_xfer_regs.sv
module dmaw_xfer_regs
  import dmaw_pkg::*;
#(
  parameter int ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_en,
  input  logic [FLD_W-1:0]  ld_sel,
  input  logic [WORD_W-1:0] ld_word,
  input  logic              step,
  output logic [ADDR_W-1:0] src_addr,
  output logic [ADDR_W-1:0] dst_addr,
  output logic              empty,
  output logic              last
);
  localparam int HI_W  = ADDR_W - WORD_W;
  localparam int CNT_W = WORD_W - WB_SHIFT;
  localparam logic [ADDR_W-1:0] STEP_B = ADDR_W'(WORD_BYTES);

  logic [ADDR_W-1:0] src_q, src_n, dst_q, dst_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic              src_en, dst_en, cnt_en;

  always_comb begin
    src_n  = src_q;
    dst_n  = dst_q;
    cnt_n  = cnt_q;
    src_en = 1'b0;
    dst_en = 1'b0;
    cnt_en = 1'b0;
    if (ld_en) begin
      unique case (ld_sel)
        FLD_SIZE: begin
          cnt_n  = ld_word[WORD_W-1:WB_SHIFT];
          cnt_en = 1'b1;
        end
        FLD_SRC_LO: begin
          src_n[WORD_W-1:0] = ld_word;
          src_en = 1'b1;
        end
        FLD_SRC_HI: begin
          src_n[ADDR_W-1:WORD_W] = ld_word[HI_W-1:0];
          src_en = 1'b1;
        end
        FLD_DST_LO: begin
          dst_n[WORD_W-1:0] = ld_word;
          dst_en = 1'b1;
        end
        FLD_DST_HI: begin
          dst_n[ADDR_W-1:WORD_W] = ld_word[HI_W-1:0];
          dst_en = 1'b1;
        end
        default: ;
      endcase
    end else if (step) begin
      src_n  = src_q + STEP_B;
      dst_n  = dst_q + STEP_B;
      cnt_n  = cnt_q - CNT_W'(1);
      src_en = 1'b1;
      dst_en = 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0;
      dst_q <= '0;
      cnt_q <= '0;
    end else begin
      if (src_en) src_q <= src_n;
      if (dst_en) dst_q <= dst_n;
      if (cnt_en) cnt_q <= cnt_n;
    end
  end

  assign src_addr = src_q;
  assign dst_addr = dst_q;
  assign empty    = (cnt_q == '0);
  assign last     = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/llwalk_dma.sv
module llwalk_dma
  import dmaw_pkg::*;
#(
  parameter int ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              db_valid,
  input  logic              cfg_llen,
  input  logic              cfg_ccs,
  input  logic [ADDR_W-1:0] cfg_list_ptr,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              mem_err,
  output logic              irq_done,
  output logic              irq_remote,
  output logic              irq_abort,
  output logic [1:0]        ch_status,
  output logic              ch_ccs
);
  localparam int HI_W = ADDR_W - WORD_W;
  localparam logic [ADDR_W-1:0] DATA_STRIDE = ADDR_W'(DATA_ELEM_WORDS * WORD_BYTES);

  walk_state_e       state_q, state_n;
  ch_status_e        stat_q, stat_n;
  logic [FLD_W-1:0]  idx_q, idx_n;
  logic [ADDR_W-1:0] ptr_q, ptr_n;
  logic              ccs_q, ccs_n;
  elem_ctl_t         ctl_q, ctl_n, rd_ctl;
  logic [WORD_W-1:0] link_q, link_n, buf_q, buf_n;
  logic              done_q, done_n, rmt_q, rmt_n, abt_q, abt_n;
  logic              fin_c, abort_c;
  logic              x_ld, x_step, x_empty, x_last;
  logic [ADDR_W-1:0] x_src, x_dst;
  logic              unused_cb;

  dmaw_ctl_decode u_decode (
    .word (mem_rdata),
    .ctl  (rd_ctl)
  );

  dmaw_xfer_regs #(.ADDR_W(ADDR_W)) u_xfer (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld_en    (x_ld),
    .ld_sel   (idx_q),
    .ld_word  (mem_rdata),
    .step     (x_step),
    .src_addr (x_src),
    .dst_addr (x_dst),
    .empty    (x_empty),
    .last     (x_last)
  );

  always_comb begin
    x_ld   = (state_q == W_FETCH) && mem_ack && !mem_err &&
             (idx_q != FLD_CTL) && !ctl_q.llp;
    x_step = (state_q == W_COPY_WR) && mem_ack && !mem_err;
  end

  // next-state logic
  always_comb begin
    state_n = state_q;
    stat_n  = stat_q;
    idx_n   = idx_q;
    ptr_n   = ptr_q;
    ccs_n   = ccs_q;
    ctl_n   = ctl_q;
    link_n  = link_q;
    buf_n   = buf_q;
    done_n  = 1'b0;
    rmt_n   = 1'b0;
    abt_n   = 1'b0;
    fin_c   = 1'b0;
    abort_c = 1'b0;
    unique case (state_q)
      W_IDLE: begin
        if (db_valid && cfg_llen) begin
          state_n = W_FETCH;
          stat_n  = CH_RUN;
          idx_n   = FLD_CTL;
          ptr_n   = cfg_list_ptr;
          ccs_n   = cfg_ccs;
        end
      end
      W_FETCH: begin
        if (mem_ack) begin
          if (mem_err) begin
            abort_c = 1'b1;
          end else if (idx_q == FLD_CTL) begin
            if (rd_ctl.cb != ccs_q) begin
              state_n = W_IDLE;
              stat_n  = CH_STOP;
            end else begin
              ctl_n = rd_ctl;
              idx_n = idx_q + FLD_W'(1);
            end
          end else if (ctl_q.llp) begin
            if (idx_q == FLD_LNK_LO) begin
              link_n = mem_rdata;
              idx_n  = idx_q + FLD_W'(1);
            end else begin
              ptr_n = {mem_rdata[HI_W-1:0], link_q};
              ccs_n = ccs_q ^ ctl_q.tcb;
              idx_n = FLD_CTL;
            end
          end else if (idx_q == FLD_DST_HI) begin
            if (x_empty) fin_c = 1'b1;
            else         state_n = W_COPY_RD;
          end else begin
            idx_n = idx_q + FLD_W'(1);
          end
        end
      end
      W_COPY_RD: begin
        if (mem_ack) begin
          if (mem_err) begin
            abort_c = 1'b1;
          end else begin
            buf_n   = mem_rdata;
            state_n = W_COPY_WR;
          end
        end
      end
      W_COPY_WR: begin
        if (mem_ack) begin
          if (mem_err)     abort_c = 1'b1;
          else if (x_last) fin_c   = 1'b1;
          else             state_n = W_COPY_RD;
        end
      end
      default: state_n = W_IDLE;
    endcase
    if (fin_c) begin
      state_n = W_FETCH;
      idx_n   = FLD_CTL;
      ptr_n   = ptr_q + DATA_STRIDE;
      done_n  = ctl_q.lie;
      rmt_n   = ctl_q.rie;
    end
    if (abort_c) begin
      state_n = W_IDLE;
      stat_n  = CH_HALT;
      abt_n   = 1'b1;
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= W_IDLE;
      stat_q  <= CH_RESET;
      idx_q   <= FLD_CTL;
      ptr_q   <= '0;
      ccs_q   <= 1'b0;
      ctl_q   <= '0;
      link_q  <= '0;
      buf_q   <= '0;
      done_q  <= 1'b0;
      rmt_q   <= 1'b0;
      abt_q   <= 1'b0;
    end else begin
      state_q <= state_n;
      stat_q  <= stat_n;
      idx_q   <= idx_n;
      ptr_q   <= ptr_n;
      ccs_q   <= ccs_n;
      ctl_q   <= ctl_n;
      link_q  <= link_n;
      buf_q   <= buf_n;
      done_q  <= done_n;
      rmt_q   <= rmt_n;
      abt_q   <= abt_n;
    end
  end

  // memory port driven straight from state
  always_comb begin
    mem_req   = (state_q != W_IDLE);
    mem_we    = (state_q == W_COPY_WR);
    mem_wdata = buf_q;
    unique case (state_q)
      W_COPY_RD: mem_addr = x_src;
      W_COPY_WR: mem_addr = x_dst;
      default:   mem_addr = ptr_q + (ADDR_W'(idx_q) << WB_SHIFT);
    endcase
  end

  assign irq_done   = done_q;
  assign irq_remote = rmt_q;
  assign irq_abort  = abt_q;
  assign ch_status  = stat_q;
  assign ch_ccs     = ccs_q;
  assign unused_cb  = ctl_q.cb;
endmodule

// File: rtl/dmaw_checker.sv
module dmaw_checker #(
  parameter int ADDR_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              db_valid,
  input logic              cfg_llen,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [31:0]       mem_wdata,
  input logic              mem_ack,
  input logic              irq_done,
  input logic              irq_remote,
  input logic              irq_abort,
  input logic [1:0]        ch_status,
  input logic              ch_ccs
);
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R10

  AST_DB_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (db_valid && cfg_llen && ch_status != 2'd1) |=> (ch_status == 2'd1)); // R2

  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_status != 2'd1) |-> !mem_req); // R6

  AST_CCS_HELD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_status != 2'd1 && !(db_valid && cfg_llen)) |=> $stable(ch_ccs)); // R6

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_done |=> !irq_done); // R8

  AST_REMOTE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_remote |=> !irq_remote); // R8

  AST_ABORT_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    irq_abort |-> (ch_status == 2'd2 && !mem_req && !irq_done)); // R9

  AST_ABORT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_abort |=> !irq_abort); // R9
endmodule

bind llwalk_dma dmaw_checker #(.ADDR_W(ADDR_W)) u_dmaw_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .db_valid   (db_valid),
  .cfg_llen   (cfg_llen),
  .mem_req    (mem_req),
  .mem_we     (mem_we),
  .mem_addr   (mem_addr),
  .mem_wdata  (mem_wdata),
  .mem_ack    (mem_ack),
  .irq_done   (irq_done),
  .irq_remote (irq_remote),
  .irq_abort  (irq_abort),
  .ch_status  (ch_status),
  .ch_ccs     (ch_ccs)
);

// File: tb/tb_llwalk_dma.sv
`timescale 1ns/1ps
module tb_llwalk_dma;
  localparam logic [31:0] C_CB = 32'h1, C_TCB = 32'h2, C_LLP = 32'h4, C_LIE = 32'h8, C_RIE = 32'h10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        db_valid, cfg_llen, cfg_ccs;
  logic [63:0] cfg_list_ptr;
  logic        mem_req, mem_we;
  logic [63:0] mem_addr;
  logic [31:0] mem_wdata;
  logic        mem_ack, mem_err;
  logic [31:0] mem_rdata;
  logic        irq_done, irq_remote, irq_abort, ch_ccs;
  logic [1:0]  ch_status;

  int checks = 0, fails = 0;
  int n_acc = 0, n_done = 0, n_rmt = 0, n_abt = 0, n_proto = 0;
  int g_acc, g_done, g_rmt, g_abt;
  int lat;
  logic [63:0] err_addr = '1;
  logic [31:0] mem [logic [63:0]];
  logic        req_p = 1'b0, ack_p = 1'b0, we_p = 1'b0;
  logic [63:0] addr_p = '0;

  always #4 clk = ~clk;

  llwalk_dma dut (
    .clk(clk), .rst_n(rst_n), .db_valid(db_valid), .cfg_llen(cfg_llen), .cfg_ccs(cfg_ccs),
    .cfg_list_ptr(cfg_list_ptr), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata), .mem_err(mem_err),
    .irq_done(irq_done), .irq_remote(irq_remote), .irq_abort(irq_abort),
    .ch_status(ch_status), .ch_ccs(ch_ccs)
  );

  function automatic logic [31:0] pat(input logic [63:0] a);
    return a[31:0] ^ a[63:32] ^ 32'h5A3C_0F96;
  endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // memory model with random latency and protocol monitor (R10)
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ack = 1'b0; mem_err = 1'b0; mem_rdata = '0; lat = 0;
      req_p = 1'b0; ack_p = 1'b0;
    end else begin
      if (req_p && !ack_p) begin
        if (!(mem_req && mem_addr == addr_p && mem_we == we_p)) n_proto++;
      end
      if (mem_ack) begin
        mem_ack = 1'b0; mem_err = 1'b0;
      end else if (mem_req) begin
        if (lat == 0) begin
          mem_ack = 1'b1;
          n_acc++;
          mem_err = (mem_addr == err_addr);
          if (mem_we) begin
            if (!mem_err) mem[mem_addr] = mem_wdata;
          end else begin
            mem_rdata = mem.exists(mem_addr) ? mem[mem_addr] : 32'hDEAD_BEEF;
          end
          lat = $urandom % 3;
        end else begin
          lat--;
        end
      end
      req_p = mem_req; ack_p = mem_ack; addr_p = mem_addr; we_p = mem_we;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (irq_done)   n_done++;
      if (irq_remote) n_rmt++;
      if (irq_abort)  n_abt++;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    chk(1'b0, "WD", "watchdog expired", 0, 0);
    summary();
  end

  task automatic put_data(input logic [63:0] a, input logic [31:0] ctl, input logic [31:0] size,
                          input logic [63:0] src, input logic [63:0] dst);
    mem[a] = ctl; mem[a+4] = size;
    mem[a+8] = src[31:0]; mem[a+12] = src[63:32];
    mem[a+16] = dst[31:0]; mem[a+20] = dst[63:32];
    for (int k = 0; k < int'(size >> 2); k++) mem[src + 64'(4*k)] = pat(src + 64'(4*k));
  endtask

  task automatic put_link(input logic [63:0] a, input logic [31:0] ctl, input logic [63:0] p);
    mem[a] = ctl; mem[a+4] = p[31:0]; mem[a+8] = p[63:32];
  endtask

  task automatic chk_copy(input string rq, input logic [63:0] src, input logic [63:0] dst, input int nvalid);
    int bad = 0;
    for (int k = 0; k < nvalid; k++) begin
      if (!mem.exists(dst + 64'(4*k))) bad++;
      else if (mem[dst + 64'(4*k)] != pat(src + 64'(4*k))) bad++;
    end
    if (mem.exists(dst + 64'(4*nvalid))) bad++;
    chk(bad == 0, rq, "copied words wrong", bad, 0);
  endtask

  task automatic run(input logic [63:0] ptr, input logic ccs, input bit intrude, input logic [63:0] iptr);
    int a0 = n_acc, d0 = n_done, r0 = n_rmt, b0 = n_abt, t = 0;
    @(negedge clk);
    cfg_list_ptr = ptr; cfg_ccs = ccs; cfg_llen = 1'b1; db_valid = 1'b1;
    @(negedge clk);
    db_valid = 1'b0;
    if (intrude) begin
      repeat (5) @(negedge clk);
      cfg_list_ptr = iptr; cfg_ccs = ~ccs; db_valid = 1'b1;
      @(negedge clk);
      db_valid = 1'b0;
    end
    while (ch_status == 2'd1 && t < 20000) begin @(negedge clk); t++; end
    chk(t < 20000, "R2", "walk did not end", 64'(t), 0);
    repeat (3) @(negedge clk);
    g_acc = n_acc - a0; g_done = n_done - d0; g_rmt = n_rmt - r0; g_abt = n_abt - b0;
  endtask

  task automatic chk_run(input string rq, input int acc, input int dn, input int rm, input int ab,
                         input logic [1:0] st, input logic cc);
    chk(g_acc == acc, rq, "access count", 64'(g_acc), 64'(acc));
    chk(g_done == dn, rq, "done pulses", 64'(g_done), 64'(dn));
    chk(g_rmt == rm, rq, "remote pulses", 64'(g_rmt), 64'(rm));
    chk(g_abt == ab, rq, "abort pulses", 64'(g_abt), 64'(ab));
    chk(ch_status == st, rq, "status", 64'(ch_status), 64'(st));
    chk(ch_ccs == cc, rq, "cycle state", 64'(ch_ccs), 64'(cc));
  endtask

  initial begin
    logic [63:0] b, s, d, p;
    void'($urandom(32'h0D5A_11C3));
    rst_n = 1'b0; db_valid = 1'b0; cfg_llen = 1'b0; cfg_ccs = 1'b0; cfg_list_ptr = '0;
    mem_ack = 1'b0; mem_err = 1'b0; mem_rdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(ch_status == 2'd0, "R1", "status after reset", 64'(ch_status), 0);
    chk(!mem_req && !irq_done && !irq_remote && !irq_abort && !ch_ccs, "R1", "outputs after reset",
        {59'd0, mem_req, irq_done, irq_remote, irq_abort, ch_ccs}, 0);

    // R3 R5 R6 R8: one element with both interrupts, then cycle mismatch
    b = 64'h1000_0000_0000_1000; s = 64'h0000_0002_0000_0100; d = 64'h0000_0003_0000_0100;
    put_data(b, C_CB | C_LIE | C_RIE, 16, s, d);
    mem[b+24] = 32'h0;
    // R2: doorbell without linked-list enable is ignored
    @(negedge clk);
    cfg_list_ptr = b; cfg_ccs = 1'b1; cfg_llen = 1'b0; db_valid = 1'b1;
    @(negedge clk);
    db_valid = 1'b0;
    repeat (10) @(negedge clk);
    chk(ch_status == 2'd0 && n_acc == 0, "R2", "doorbell with enable low started walk", 64'(n_acc), 0);
    run(b, 1'b1, 1'b0, '0);
    chk_run("R3", 15, 1, 1, 0, 2'd3, 1'b1);
    chk_copy("R5", s, d, 4);

    // R7 R4: link that inverts the cycle state
    b = 64'h2000; s = 64'h0000_0002_0000_0400; d = 64'h0000_0003_0000_0400;
    p = 64'h0000_0001_0000_3000;
    put_data(b, 32'h0, 8, s, d);
    put_link(b+24, C_LLP | C_TCB, p);
    put_data(p, C_CB | C_LIE, 12, s + 64'h100, d + 64'h100);
    mem[p+24] = 32'h0;
    run(b, 1'b0, 1'b0, '0);
    chk_run("R7", 26, 1, 0, 0, 2'd3, 1'b1);
    chk_copy("R7", s, d, 2);
    chk_copy("R4", s + 64'h100, d + 64'h100, 3);

    // R7: link without inversion keeps the cycle state
    b = 64'h4000; p = 64'h0000_0001_0000_5000; s = 64'h0000_0002_0000_0800; d = 64'h0000_0003_0000_0800;
    put_link(b, C_LLP | C_CB, p);
    put_data(p, C_CB | C_RIE, 4, s, d);
    mem[p+24] = 32'h0;
    run(b, 1'b1, 1'b0, '0);
    chk_run("R7", 12, 0, 1, 0, 2'd3, 1'b1);
    chk_copy("R8", s, d, 1);

    // R5 boundary: counts 0 and 3 move nothing
    b = 64'h6000; s = 64'h0000_0002_0000_0C00; d = 64'h0000_0003_0000_0C00;
    put_data(b, C_LIE, 0, s, d);
    put_data(b+24, C_LIE, 3, s + 64'h40, d + 64'h40);
    mem[b+48] = C_CB;
    run(b, 1'b0, 1'b0, '0);
    chk_run("R5", 13, 2, 0, 0, 2'd3, 1'b0);
    chk_copy("R5", s, d, 0);
    chk_copy("R5", s + 64'h40, d + 64'h40, 0);

    // R9: error on third source read
    b = 64'h7000; s = 64'h0000_0002_0000_1000; d = 64'h0000_0003_0000_1000;
    put_data(b, C_CB | C_LIE, 16, s, d);
    err_addr = s + 64'd8;
    run(b, 1'b1, 1'b0, '0);
    chk_run("R9", 11, 0, 0, 1, 2'd2, 1'b1);
    chk_copy("R9", s, d, 2);
    err_addr = '1;

    // R11: restart after abort
    b = 64'h8000; s = 64'h0000_0002_0000_1400; d = 64'h0000_0003_0000_1400;
    put_data(b, C_LIE, 4, s, d);
    mem[b+24] = C_CB;
    run(b, 1'b0, 1'b0, '0);
    chk_run("R11", 9, 1, 0, 0, 2'd3, 1'b0);
    chk_copy("R11", s, d, 1);

    // R2: doorbell during a walk is ignored
    b = 64'h9000; s = 64'h0000_0002_0000_1800; d = 64'h0000_0003_0000_1800;
    put_data(b, C_CB | C_LIE, 40, s, d);
    mem[b+24] = 32'h0;
    put_data(64'hA000, C_RIE, 4, s + 64'h80, d + 64'h80);
    run(b, 1'b1, 1'b1, 64'hA000);
    chk_run("R2", 27, 1, 0, 0, 2'd3, 1'b1);
    chk_copy("R2", s, d, 10);

    // random chains, cycle state alternating per submission
    for (int it = 0; it < 8; it++) begin
      logic [63:0] srcs [6];
      logic [63:0] dsts [6];
      int          nws [6];
      logic        cc, cc0;
      logic [63:0] cur;
      int          nel, acc, dn, rm;
      bit          linked;
      cc0 = it[0]; cc = cc0; cur = 64'h6000_0000 + 64'(it) * 64'h1000;
      nel = 1 + int'($urandom % 5); acc = 1; dn = 0; rm = 0; linked = 1'b0;
      for (int e = 0; e < nel; e++) begin
        logic [31:0] ctl, sz;
        if (e > 0 && !linked && ($urandom % 2) == 1) begin
          logic tg;
          tg = 1'($urandom % 2);
          put_link(cur, C_LLP | (tg ? C_TCB : 32'h0) | (cc ? C_CB : 32'h0),
                   64'h6000_0000 + 64'(it) * 64'h1000 + 64'h800);
          cur = 64'h6000_0000 + 64'(it) * 64'h1000 + 64'h800;
          cc = cc ^ tg; acc += 3; linked = 1'b1;
        end
        sz = ($urandom % 9) * 4 + (($urandom % 4 == 0) ? ($urandom % 4) : 0);
        ctl = (cc ? C_CB : 32'h0) | ((($urandom % 2) == 1) ? C_LIE : 32'h0) |
              ((e == nel - 1) ? C_RIE : 32'h0);
        srcs[e] = 64'h0000_0004_0000_0000 + 64'(it) * 64'h10000 + 64'(e) * 64'h100;
        dsts[e] = 64'h0000_0005_0000_0000 + 64'(it) * 64'h10000 + 64'(e) * 64'h100;
        nws[e] = int'(sz >> 2);
        put_data(cur, ctl, sz, srcs[e], dsts[e]);
        acc += 6 + 2 * nws[e];
        if (ctl[3]) dn++;
        if (ctl[4]) rm++;
        cur = cur + 64'd24;
      end
      mem[cur] = cc ? 32'h0 : C_CB;
      run(64'h6000_0000 + 64'(it) * 64'h1000, cc0, 1'b0, '0);
      chk_run("R6", acc, dn, rm, 0, 2'd3, cc);
      for (int e = 0; e < nel; e++) chk_copy("R5", srcs[e], dsts[e], nws[e]);
    end

    chk(n_proto == 0, "R10", "request changed before ack", 64'(n_proto), 0);
    summary();
  end
endmodule